// File: doc/BRIEF.md
# Write Phase-Ordering Gate for a Bus Master

This block sits in the request path of a bus master that keeps separate request, write-data and response phases. Each cycle it looks at the command at the head of the master's queue (read or write, plus its address) and at the handshake signals of the three phases. From these it produces two enables. The first says whether that head command may be presented as a request. The second says whether write data may be driven.

The rules keep a write from overtaking an older read to the same address. Reads whose requests have been accepted are held in a small in-order table until their responses are accepted.

Two independent configuration bits pick an optimistic or a pessimistic rule:
- The data-phase bit governs when write data may start, relative to the write's own request and to older overlapping reads.
- The request bit governs when a write request may start, relative to older overlapping reads. It applies only when data travels with the request.

A third input says whether the bus uses a separate data phase.

Top module: `phase_gate`

## Requirements
- R1: After reset no read is tracked and no write data is pending. A read head and a write head are both enabled (`req_go_o`=1), and `data_go_o` is 0 while no write is presented.
- R2: Two addresses overlap when they are equal above bit BLK_LSB (default 2). Address 5 overlaps 4; address 8 does not overlap 4.
- R3: With a separate data phase (`cfg_sep_data_i`=1), a write request is never held back by outstanding reads.
- R4: With the data rule optimistic (`cfg_dh_pess_i`=0), write data may be driven in the same cycle the write request is first presented (`req_valid_i`=1), before it is accepted.
- R5: With the data rule pessimistic (`cfg_dh_pess_i`=1), write data is enabled only from the cycle its request is accepted (`req_accept_i`=1) onward.
- R6: Write data waits for every older read to an overlapping address. Under the optimistic rule it waits until that read's response has started (`resp_valid_i`=1). Under the pessimistic rule it waits until the response is accepted (`resp_valid_i` and `resp_accept_i` both 1); the accepting cycle itself counts.
- R7: Without a separate data phase (`cfg_sep_data_i`=0), a write request waits for every older overlapping read. With `cfg_req_pess_i`=0 it waits until that read's response has started; with `cfg_req_pess_i`=1 it waits until the response is accepted.
- R8: A write with no overlapping outstanding read is never delayed by the read table.
- R9: Reads accepted after a write request was accepted never hold back that write's data.
- R10: The table holds NRD (default 4) reads. A read head is disabled while it is full, and an entry is freed the cycle after its response is accepted.
- R11: Only one write's data may be pending. Another write head is disabled until the pending data completes (`dat_valid_i` and `dat_accept_i` both 1). Data that completes before the request is accepted leaves nothing pending, and `data_go_o` stays 0 for the rest of that request.
- R12: Without a separate data phase, `data_go_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sep_data_i | input | 1 | 1: separate write-data phase; 0: data travels with the request |
| cfg_dh_pess_i | input | 1 | Write-data rule: 0 optimistic, 1 pessimistic |
| cfg_req_pess_i | input | 1 | Write-request rule (combined mode only): 0 optimistic, 1 pessimistic |
| cmd_valid_i | input | 1 | Head command present |
| cmd_write_i | input | 1 | Head command is a write |
| cmd_addr_i | input | AW | Head command address |
| req_go_o | output | 1 | Head command may be presented as a request |
| req_valid_i | input | 1 | Master presents the head command this cycle |
| req_accept_i | input | 1 | Slave accepts the presented request |
| data_go_o | output | 1 | Write data may be driven |
| dat_valid_i | input | 1 | Master drives write data |
| dat_accept_i | input | 1 | Slave accepts write data |
| resp_valid_i | input | 1 | Response non-idle, for the oldest tracked read |
| resp_accept_i | input | 1 | Master accepts the response |

## Verification
The hardest situation to reach is a write whose data is pending while the overlapping older read moves through its response: not started, started but not accepted, accepted in the current cycle, and freed. In that situation the data enable must change at each step in a way that depends on the data rule.

The bench reaches it with a fixed scripted sequence run for every combination of the three configuration bits and for an overlapping and a non-overlapping address:
- a read is accepted;
- the write is presented and then accepted;
- the response is walked through its stages one cycle at a time.

Separate sequences fill the table, issue a younger read behind a pending write, and complete data before the request is accepted.

// File: rtl/phase_gate_pkg.sv
package phase_gate_pkg;
  typedef enum logic {RULE_OPT = 1'b0, RULE_PESS = 1'b1} rule_e;

  // one tracked read satisfies the rule this cycle
  function automatic logic rule_met(rule_e rule, logic started, logic is_head,
                                    logic rv, logic ra);
    if (rule == RULE_PESS) return is_head & rv & ra;
    return started | (is_head & rv);
  endfunction
endpackage

// File: rtl/rd_table.sv
module rd_table #(
  parameter int NRD     = 4,
  parameter int AW      = 16,
  parameter int BLK_LSB = 2,
  localparam int IW     = (NRD > 1) ? $clog2(NRD) : 1,
  localparam int CW     = $clog2(NRD + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           alloc_i,
  input  logic [AW-1:0]  alloc_addr_i,
  input  logic           resp_valid_i,
  input  logic           resp_accept_i,
  input  logic [AW-1:0]  cmp_addr_i,
  output logic [NRD-1:0] started_o,
  output logic [NRD-1:0] head_o,
  output logic [NRD-1:0] ovl_o,
  output logic [NRD-1:0] free_o,
  output logic [CW-1:0]  cnt_o,
  output logic           full_o
);
  logic [NRD-1:0]         vld_q, strt_q;
  logic [NRD-1:0][AW-1:0] addr_q;
  logic [IW-1:0]          wp_q, rp_q;
  logic [CW-1:0]          cnt_q;
  logic                   pop, push;

  assign full_o = (cnt_q == CW'(NRD));
  assign push   = alloc_i & ~full_o;
  assign pop    = resp_valid_i & resp_accept_i & (cnt_q != '0);
  assign cnt_o  = cnt_q;

  function automatic logic [IW-1:0] nxt(logic [IW-1:0] p);
    return (p == IW'(NRD - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < NRD; i++) begin : g_ent
    assign head_o[i]    = vld_q[i] & (rp_q == IW'(i));
    assign started_o[i] = strt_q[i];
    assign free_o[i]    = head_o[i] & pop;
    assign ovl_o[i]     = vld_q[i] &
                          (addr_q[i][AW-1:BLK_LSB] == cmp_addr_i[AW-1:BLK_LSB]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i]  <= 1'b0;
        strt_q[i] <= 1'b0;
        addr_q[i] <= '0;
      end else if (push && wp_q == IW'(i)) begin
        vld_q[i]  <= 1'b1;
        strt_q[i] <= 1'b0;
        addr_q[i] <= alloc_addr_i;
      end else if (free_o[i]) begin
        vld_q[i]  <= 1'b0;
        strt_q[i] <= 1'b0;
      end else if (head_o[i] && resp_valid_i) begin
        strt_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= nxt(wp_q);
      if (pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/ovl_block.sv
module ovl_block
  import phase_gate_pkg::*;
#(
  parameter int NRD = 4
) (
  input  logic [NRD-1:0] cand_i,
  input  rule_e          rule_i,
  input  logic [NRD-1:0] started_i,
  input  logic [NRD-1:0] head_i,
  input  logic           resp_valid_i,
  input  logic           resp_accept_i,
  output logic           block_o
);
  logic [NRD-1:0] met;
  for (genvar i = 0; i < NRD; i++) begin : g_met
    assign met[i] = rule_met(rule_i, started_i[i], head_i[i], resp_valid_i, resp_accept_i);
  end
  assign block_o = |(cand_i & ~met);
endmodule

// File: rtl/wr_track.sv
module wr_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sep_i,
  input  logic wr_pres_i,
  input  logic wr_acc_i,
  input  logic dat_done_i,
  output logic pend_o,
  output logic early_o
);
  logic pend_q, early_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      early_q <= 1'b0;
    end else begin
      if (wr_acc_i)                            early_q <= 1'b0;
      else if (sep_i && wr_pres_i && dat_done_i) early_q <= 1'b1;

      if (pend_q && dat_done_i)                              pend_q <= 1'b0;
      else if (sep_i && wr_acc_i && !early_q && !dat_done_i) pend_q <= 1'b1;
    end
  end

  assign pend_o  = pend_q;
  assign early_o = early_q;
endmodule

// File: rtl/phase_gate.sv
module phase_gate
  import phase_gate_pkg::*;
#(
  parameter int NRD     = 4,
  parameter int AW      = 16,
  parameter int BLK_LSB = 2,
  localparam int CW     = $clog2(NRD + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_sep_data_i,
  input  logic          cfg_dh_pess_i,
  input  logic          cfg_req_pess_i,
  input  logic          cmd_valid_i,
  input  logic          cmd_write_i,
  input  logic [AW-1:0] cmd_addr_i,
  output logic          req_go_o,
  input  logic          req_valid_i,
  input  logic          req_accept_i,
  output logic          data_go_o,
  input  logic          dat_valid_i,
  input  logic          dat_accept_i,
  input  logic          resp_valid_i,
  input  logic          resp_accept_i
);
  logic [NRD-1:0] started, head, ovl, free, mask_q;
  logic [CW-1:0]  rd_cnt;
  logic           full, rd_alloc, wr_pres, wr_acc, dat_done;
  logic           wr_pend_q, early_q;
  logic           blk_req, blk_dlive, blk_dpend;
  rule_e          req_rule, dh_rule;

  assign req_rule = rule_e'(cfg_req_pess_i);
  assign dh_rule  = rule_e'(cfg_dh_pess_i);
  assign rd_alloc = cmd_valid_i & ~cmd_write_i & req_valid_i & req_accept_i;
  assign wr_pres  = cmd_valid_i &  cmd_write_i & req_valid_i;
  assign wr_acc   = wr_pres & req_accept_i;
  assign dat_done = dat_valid_i & dat_accept_i;

  rd_table #(.NRD(NRD), .AW(AW), .BLK_LSB(BLK_LSB)) u_tbl (
    .clk_i, .rst_ni,
    .alloc_i      (rd_alloc),
    .alloc_addr_i (cmd_addr_i),
    .resp_valid_i, .resp_accept_i,
    .cmp_addr_i   (cmd_addr_i),
    .started_o    (started),
    .head_o       (head),
    .ovl_o        (ovl),
    .free_o       (free),
    .cnt_o        (rd_cnt),
    .full_o       (full)
  );

  ovl_block #(.NRD(NRD)) u_blk_req (
    .cand_i (ovl), .rule_i (req_rule), .started_i (started), .head_i (head),
    .resp_valid_i, .resp_accept_i, .block_o (blk_req)
  );
  ovl_block #(.NRD(NRD)) u_blk_dlive (
    .cand_i (ovl), .rule_i (dh_rule), .started_i (started), .head_i (head),
    .resp_valid_i, .resp_accept_i, .block_o (blk_dlive)
  );
  ovl_block #(.NRD(NRD)) u_blk_dpend (
    .cand_i (mask_q), .rule_i (dh_rule), .started_i (started), .head_i (head),
    .resp_valid_i, .resp_accept_i, .block_o (blk_dpend)
  );

  wr_track u_wr (
    .clk_i, .rst_ni,
    .sep_i      (cfg_sep_data_i),
    .wr_pres_i  (wr_pres),
    .wr_acc_i   (wr_acc),
    .dat_done_i (dat_done),
    .pend_o     (wr_pend_q),
    .early_o    (early_q)
  );

  // older overlapping reads snapshotted at write accept; cleared as they free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mask_q <= '0;
    else if (wr_acc && cfg_sep_data_i)  mask_q <= ovl & ~free;
    else                                mask_q <= mask_q & ~free;
  end

  always_comb begin
    req_go_o = 1'b0;
    if (cmd_valid_i) begin
      if (!cmd_write_i)        req_go_o = ~full;
      else if (cfg_sep_data_i) req_go_o = ~wr_pend_q;
      else                     req_go_o = ~blk_req;
    end
  end

  always_comb begin
    data_go_o = 1'b0;
    if (cfg_sep_data_i) begin
      if (wr_pend_q)
        data_go_o = ~blk_dpend;
      else
        data_go_o = wr_pres & ~early_q & ~blk_dlive &
                    (cfg_dh_pess_i ? req_accept_i : 1'b1);
    end
  end
endmodule

// File: rtl/phase_gate_chk.sv
module phase_gate_chk #(
  parameter int NRD = 4,
  localparam int CW = $clog2(NRD + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_sep_data_i,
  input logic          cfg_dh_pess_i,
  input logic          cmd_valid_i,
  input logic          cmd_write_i,
  input logic          req_accept_i,
  input logic          req_go_o,
  input logic          data_go_o,
  input logic          dat_valid_i,
  input logic          dat_accept_i,
  input logic          wr_pend_q,
  input logic [CW-1:0] rd_cnt
);
  AST_DATA_NEEDS_SEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_go_o |-> cfg_sep_data_i); // R12
  AST_PESS_DATA_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_go_o && cfg_dh_pess_i && !wr_pend_q) |-> req_accept_i); // R5
  AST_FULL_BLOCKS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cnt == CW'(NRD) && cmd_valid_i && !cmd_write_i) |-> !req_go_o); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt <= CW'(NRD)); // R10
  AST_ONE_WR_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pend_q && cmd_valid_i && cmd_write_i) |-> !req_go_o); // R11
  AST_PEND_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pend_q && dat_valid_i && dat_accept_i) |=> !wr_pend_q); // R11
  AST_SEP_WR_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sep_data_i && cmd_valid_i && cmd_write_i && !wr_pend_q) |-> req_go_o); // R3
endmodule

bind phase_gate phase_gate_chk #(.NRD(NRD)) u_chk (
  .clk_i, .rst_ni, .cfg_sep_data_i, .cfg_dh_pess_i, .cmd_valid_i, .cmd_write_i,
  .req_accept_i, .req_go_o, .data_go_o, .dat_valid_i, .dat_accept_i,
  .wr_pend_q, .rd_cnt
);

// File: tb/phase_gate_tb.sv
module phase_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sep, dhp, rqp, cv, cw, rv, ra, dv, da, sv, sa;
  logic [AW-1:0] addr;
  logic req_go, data_go;
  int checks = 0, fails = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_gate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_sep_data_i(sep), .cfg_dh_pess_i(dhp),
    .cfg_req_pess_i(rqp), .cmd_valid_i(cv), .cmd_write_i(cw), .cmd_addr_i(addr),
    .req_go_o(req_go), .req_valid_i(rv), .req_accept_i(ra), .data_go_o(data_go),
    .dat_valid_i(dv), .dat_accept_i(da), .resp_valid_i(sv), .resp_accept_i(sa)
  );

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b (sep=%0b dhp=%0b rqp=%0b)",
               tag, got, exp, sep, dhp, rqp);
    end
  endtask

  task automatic idle();
    cv = 0; cw = 0; rv = 0; ra = 0; dv = 0; da = 0; sv = 0; sa = 0; addr = '0;
  endtask

  task automatic do_reset(bit s, bit d, bit q);
    @(negedge clk);
    idle(); sep = s; dhp = d; rqp = q; rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic rd_accept(logic [AW-1:0] a);
    cv = 1; cw = 0; addr = a; rv = 1; ra = 1; step();
  endtask

  // separate data phase: read to 4, then write to 5 (overlap) or 8
  task automatic sep_case(bit d, bit q, bit ov);
    logic [AW-1:0] wa;
    wa = ov ? 16'd5 : 16'd8;
    do_reset(1, d, q);
    rd_accept(16'd4);
    cv = 1; cw = 1; addr = wa; #1;
    chk("R3 wr req free", req_go, 1'b1);
    rv = 1; #1;
    chk("R4/R5/R6 data at present", data_go, !d && !ov);
    ra = 1; #1;
    chk("R5/R6/R8 data at accept", data_go, !ov);
    step();
    cv = 1; cw = 1; addr = 16'd12; #1;
    chk("R11 2nd wr blocked", req_go, 1'b0);
    chk("R6 pend no resp", data_go, !ov);
    cv = 0; sv = 1; #1;
    chk("R6 resp started", data_go, !ov || !d);
    step();
    sv = 1; sa = 1; #1;
    chk("R6 resp accepting", data_go, 1'b1);
    step();
    #1 chk("R10 entry freed", data_go, 1'b1);
    dv = 1; da = 1; step();
    cv = 1; cw = 1; addr = 16'd12; #1;
    chk("R11 data done no pend", data_go, 1'b0);
    chk("R11 wr head free again", req_go, 1'b1);
  endtask

  // data with request: read to 4, then write to 6 (overlap) or 8
  task automatic comb_case(bit d, bit q, bit ov);
    do_reset(0, d, q);
    rd_accept(16'd4);
    cv = 1; cw = 1; addr = ov ? 16'd6 : 16'd8; #1;
    chk("R7/R8 wr req no resp", req_go, !ov);
    rv = 1; ra = 1; #1;
    chk("R12 no data phase", data_go, 1'b0);
    rv = 0; ra = 0; sv = 1; #1;
    chk("R7 resp started", req_go, !ov || !q);
    step();
    cv = 1; cw = 1; addr = ov ? 16'd6 : 16'd8; sv = 1; sa = 1; #1;
    chk("R7 resp accepting", req_go, 1'b1);
    step();
    cv = 1; cw = 1; addr = ov ? 16'd6 : 16'd8; #1;
    chk("R7 freed", req_go, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(); sep = 1; dhp = 0; rqp = 0;
    // R1 reset state
    do_reset(1, 0, 0);
    cv = 1; cw = 0; #1 chk("R1 read head", req_go, 1'b1);
    cw = 1; #1 chk("R1 write head", req_go, 1'b1);
    chk("R1 no data", data_go, 1'b0);

    for (int c = 0; c < 8; c++) begin
      sep_case(c[0], c[1], c[2]);
      comb_case(c[0], c[1], c[2]);
    end

    // R2 overlap granularity: 7 overlaps 4, 8 does not
    do_reset(0, 0, 1);
    rd_accept(16'd4);
    cv = 1; cw = 1; addr = 16'd7; #1 chk("R2 7 overlaps 4", req_go, 1'b0);
    addr = 16'd8; #1 chk("R2 8 not overlap 4", req_go, 1'b1);

    // R10 table full
    do_reset(1, 1, 1);
    for (int i = 0; i < 4; i++) rd_accept(AW'(16 * i + 64));
    cv = 1; cw = 0; addr = 16'd0; #1 chk("R10 full blocks read", req_go, 1'b0);
    cw = 1; #1 chk("R10 full write ok", req_go, 1'b1);
    cv = 0; sv = 1; sa = 1; step();
    cv = 1; cw = 0; #1 chk("R10 read after free", req_go, 1'b1);

    // R9 younger read does not gate pending data
    for (int d = 0; d < 2; d++) begin
      do_reset(1, d[0], 0);
      cv = 1; cw = 1; addr = 16'd4; rv = 1; ra = 1; step();
      rd_accept(16'd4);
      #1 chk("R9 younger read ignored", data_go, 1'b1);
    end

    // R11 data done before accept
    do_reset(1, 0, 0);
    cv = 1; cw = 1; addr = 16'd20; rv = 1; #1;
    chk("R4 early data", data_go, 1'b1);
    dv = 1; da = 1; step();
    cv = 1; cw = 1; addr = 16'd20; rv = 1; #1;
    chk("R11 no second data", data_go, 1'b0);
    ra = 1; step();
    cv = 1; cw = 1; addr = 16'd24; #1;
    chk("R11 nothing pending", req_go, 1'b1);
    chk("R11 idle data", data_go, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule